// File: doc/BRIEF.md
# Mode-Switchable Pipelined Processing Array

This block is a fixed grid of single-bit processing cells. It is organised as a number of stages, each one as wide as the input vector; by default there are four stages of eight cells. An input vector enters the first stage, and the last stage drives the result. Every cell combines two neighbouring bits from the stage before it. The bit pair wraps around at the top of the vector. Each stage applies one fixed operation.

A single mode input selects how the same cells are timed. In combinational mode, every stage feeds the next one directly, so the result follows the input within the same cycle. In pipelined mode, a register bank after each stage is switched into the path. The array then accepts one new vector per cycle and delivers each result a fixed number of cycles later.

Both modes use the same cells. Only registers and 2:1 selectors are added to support them. A valid flag travels with the data through the array. When the mode changes, any result still in flight is discarded.

Top module: `pe_grid_top`

## Requirements
- R1: With the mode register at 0 (combinational), `res_o` equals the array function of `vec_i` and `res_valid_o` equals `vec_valid_i` in the same cycle.
- R2: With the mode register at 1 (pipelined), a vector presented in cycle t appears on `res_o` in cycle t+4 with its valid flag. A new vector is accepted every cycle.
- R3: Each stage s (counted from 0) computes bit i as op(x[i], x[(i+1) mod 8]) of its input x. The operation is XOR for s mod 4 = 0, OR for 1, AND for 2 and XNOR for 3. The output of an XOR stage therefore always has even parity.
- R4: `pipe_mode_i` is sampled at a rising clock edge. In the cycle in which the input changes, the array still behaves in the previous mode.
- R5: After a switch into pipelined mode, `res_valid_o` stays low until vectors presented after the switch have passed through all four stages.
- R6: After a switch into combinational mode, results that were in flight are dropped. From the first cycle after the switch edge, the output follows the input directly.
- R7: While the asynchronous active-low reset is held, and until its synchronised release, `res_valid_o` is 0. After reset the mode is combinational.
- R8: In pipelined mode, a cycle with `vec_valid_i` low produces a cycle with `res_valid_o` low four cycles later. The vectors around that gap keep their order and their results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| pipe_mode_i | input | 1 | 0 = combinational, 1 = pipelined |
| vec_valid_i | input | 1 | Input vector is valid |
| vec_i | input | 8 | Primary input vector |
| res_valid_o | output | 1 | Result is valid |
| res_o | output | 8 | Primary output vector |

## Verification
The assertions assume that `pipe_mode_i` and `vec_valid_i` are stable around each rising edge. The latency assertion assumes that any result reported valid in pipelined mode came from a valid input exactly four edges earlier. The bench meets these assumptions by changing every input only on the falling edge. It changes the mode only through one task, which then waits for the next rising edge. Expected results come from a separate stage-by-stage model that is driven with walking-one, all-zero, all-one and mixed vectors.

// File: rtl/pe_grid_pkg.sv
package pe_grid_pkg;

  typedef enum logic [1:0] {
    OP_XOR  = 2'd0,
    OP_OR   = 2'd1,
    OP_AND  = 2'd2,
    OP_XNOR = 2'd3
  } pe_op_e;

  // Operation used by stage number k (counted from 0)
  function automatic pe_op_e stage_op(input int k);
    case (k % 4)
      0:       stage_op = OP_XOR;
      1:       stage_op = OP_OR;
      2:       stage_op = OP_AND;
      default: stage_op = OP_XNOR;
    endcase
  endfunction

endpackage

// File: rtl/pe_cell.sv
module pe_cell
  import pe_grid_pkg::*;
#(
  parameter pe_op_e OP = OP_XOR
) (
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);

  always_comb begin
    case (OP)
      OP_XOR:  y_o = a_i ^ b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_AND:  y_o = a_i & b_i;
      default: y_o = ~(a_i ^ b_i);
    endcase
  end

endmodule

// File: rtl/pe_stage.sv
module pe_stage
  import pe_grid_pkg::*;
#(
  parameter int     W  = 8,
  parameter pe_op_e OP = OP_XOR
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);

  // One cell per bit; each cell pairs a bit with its upper neighbour, wrapping at the top
  for (genvar i = 0; i < W; i++) begin : g_cell
    localparam int NB = (i + 1) % W;
    pe_cell #(.OP(OP)) i_cell (
      .a_i (x_i[i]),
      .b_i (x_i[NB]),
      .y_o (y_o[i])
    );
  end

endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         en_i,     // capture enable (pipelined mode)
  input  logic         clr_i,    // drop in-flight valid on mode change
  input  logic         sel_i,    // 1: registered path, 0: bypass
  input  logic [W-1:0] d_i,
  input  logic         v_i,
  output logic [W-1:0] d_o,
  output logic         v_o
);

  logic [W-1:0] d_q, d_d;
  logic         v_q, v_d;

  // next state
  always_comb begin
    d_d = d_q;
    v_d = v_q;
    if (en_i) begin
      d_d = d_i;
      v_d = v_i;
    end
    if (clr_i) v_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      d_q <= '0;
      v_q <= 1'b0;
    end else begin
      d_q <= d_d;
      v_q <= v_d;
    end
  end

  // bypass selection
  assign d_o = sel_i ? d_q : d_i;
  assign v_o = sel_i ? v_q : v_i;

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic rst_ns_o,
  output logic mode_q_o,
  output logic switch_o
);

  logic sync1_q, sync2_q;
  logic mode_q, mode_d;

  // reset synchroniser: asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  assign rst_ns_o = sync2_q;

  // next state
  always_comb begin
    mode_d = mode_i;
  end

  // registers
  always_ff @(posedge clk or negedge sync2_q) begin
    if (!sync2_q) mode_q <= 1'b0;
    else          mode_q <= mode_d;
  end

  assign mode_q_o = mode_q;
  assign switch_o = mode_i != mode_q;

  // R7
  rst_hold_chk: assert property (@(posedge clk) !rst_n |-> !rst_ns_o)
    else $error("reset synchroniser released while reset held");

endmodule

// File: rtl/pe_grid_top.sv
module pe_grid_top
  import pe_grid_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pipe_mode_i,
  input  logic         vec_valid_i,
  input  logic [W-1:0] vec_i,
  output logic         res_valid_o,
  output logic [W-1:0] res_o
);

  localparam int LAST = STAGES - 1;

  logic rst_ns, mode_q, mode_switch;

  logic [W-1:0] st_in  [STAGES];
  logic [W-1:0] st_out [STAGES];
  logic [W-1:0] st_sel [STAGES];
  logic         v_in   [STAGES];
  logic         v_sel  [STAGES];

  mode_ctrl i_mode_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (pipe_mode_i),
    .rst_ns_o (rst_ns),
    .mode_q_o (mode_q),
    .switch_o (mode_switch)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign st_in[k] = vec_i;
      assign v_in[k]  = vec_valid_i;
    end else begin : g_next
      assign st_in[k] = st_sel[k-1];
      assign v_in[k]  = v_sel[k-1];
    end

    pe_stage #(.W(W), .OP(stage_op(k))) i_pe_stage (
      .x_i (st_in[k]),
      .y_o (st_out[k])
    );

    stage_reg #(.W(W)) i_stage_reg (
      .clk    (clk),
      .rst_ns (rst_ns),
      .en_i   (mode_q),
      .clr_i  (mode_switch),
      .sel_i  (mode_q),
      .d_i    (st_out[k]),
      .v_i    (v_in[k]),
      .d_o    (st_sel[k]),
      .v_o    (v_sel[k])
    );

    if (stage_op(k) == OP_XOR) begin : g_par
      // R3
      xor_parity_chk: assert property (@(posedge clk) disable iff (!rst_ns)
        (^st_out[k]) == 1'b0)
        else $error("XOR stage %0d output parity odd", k);
    end
  end

  assign res_o       = st_sel[LAST];
  assign res_valid_o = v_sel[LAST] & rst_ns;

  // R1
  bypass_valid_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !mode_q |-> (res_valid_o == vec_valid_i))
    else $error("combinational valid mismatch");

  // R5
  refill_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(mode_q) |-> !res_valid_o)
    else $error("valid result right after switch to pipelined");

  // R2
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_q && res_valid_o) |-> $past(vec_valid_i, STAGES))
    else $error("pipelined valid without matching input");

  // R7
  always_comb begin
    if (!rst_ns) begin
      reset_valid_chk: assert (!res_valid_o)
        else $error("valid during reset");
    end
  end

endmodule

// File: tb/test_pe_grid_top.sv
module test_pe_grid_top;

  localparam int W = 8;
  localparam int S = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pipe_mode_i;
  logic         vec_valid_i;
  logic [W-1:0] vec_i;
  logic         res_valid_o;
  logic [W-1:0] res_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pe_grid_top #(.W(W), .STAGES(S)) i_pe_grid_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .pipe_mode_i (pipe_mode_i),
    .vec_valid_i (vec_valid_i),
    .vec_i       (vec_i),
    .res_valid_o (res_valid_o),
    .res_o       (res_o)
  );

  function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
    logic [W-1:0] c, n;
    c = x;
    for (int s = 0; s < S; s++) begin
      for (int i = 0; i < W; i++) begin
        logic a, b;
        a = c[i];
        b = c[(i+1)%W];
        case (s % 4)
          0:       n[i] = a ^ b;
          1:       n[i] = a | b;
          2:       n[i] = a & b;
          default: n[i] = ~(a ^ b);
        endcase
      end
      c = n;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 5 ns later (before next rising edge)
  task automatic drive(input logic v, input logic [W-1:0] d);
    @(negedge clk);
    vec_valid_i = v;
    vec_i       = d;
    #5;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    pipe_mode_i = m;
    vec_valid_i = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pipe_mode_i = 1'b0; vec_valid_i = 1'b1; vec_i = 8'hA5;
    repeat (3) @(posedge clk);
    #5;
    chk("R7 valid in reset", res_valid_o, 0);
    @(negedge clk); rst_n = 1'b1;
    #5;
    chk("R7 valid before sync release", res_valid_o, 0);
    repeat (3) @(posedge clk);
    drive(1'b1, 8'h3C);
    chk("R7 comb mode after reset valid", res_valid_o, 1);
    chk("R7 comb mode after reset data", res_o, ref_f(8'h3C));
  endtask

  task automatic t_comb;
    logic [W-1:0] pats [6] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hC3};
    foreach (pats[j]) begin
      drive(1'b1, pats[j]);
      chk("R1 R3 comb data", res_o, ref_f(pats[j]));
      chk("R1 comb valid", res_valid_o, 1);
    end
    for (int i = 0; i < W; i++) begin
      drive(1'b1, 8'(1) << i);
      chk("R3 walking one", res_o, ref_f(8'(1) << i));
    end
    drive(1'b0, 8'h77);
    chk("R1 comb invalid", res_valid_o, 0);
  endtask

  task automatic t_pipe;
    logic [W-1:0] vin [12];
    logic         vv  [12];
    // R4: mode change is not visible in the cycle it is driven
    @(negedge clk);
    pipe_mode_i = 1'b1; vec_valid_i = 1'b1; vec_i = 8'h96;
    #5;
    chk("R4 still comb", res_o, ref_f(8'h96));
    chk("R4 still comb valid", res_valid_o, 1);
    for (int j = 0; j < 12; j++) begin
      vin[j] = 8'(j * 37 + 11);
      vv[j]  = (j != 6);
    end
    for (int j = 0; j < 12; j++) begin
      drive(vv[j], vin[j]);
      if (j < S) chk("R5 refill invalid", res_valid_o, 0);
      else begin
        chk("R2 R8 pipe valid", res_valid_o, vv[j-S]);
        if (vv[j-S]) chk("R2 pipe data", res_o, ref_f(vin[j-S]));
      end
    end
  endtask

  task automatic t_down;
    // leave vectors in flight, then switch back
    drive(1'b1, 8'h11);
    drive(1'b1, 8'h22);
    @(negedge clk);
    pipe_mode_i = 1'b0; vec_valid_i = 1'b1; vec_i = 8'h44;
    #5;
    drive(1'b1, 8'hE7);
    chk("R6 comb after switch data", res_o, ref_f(8'hE7));
    chk("R6 comb after switch valid", res_valid_o, 1);
    drive(1'b0, 8'h00);
    chk("R6 no stale valid", res_valid_o, 0);
  endtask

  task automatic t_bubble_switch;
    set_mode(1'b1);
    for (int j = 0; j < S; j++) begin
      drive(1'b1, 8'(8'hF0 + j));
      chk("R5 refill after set_mode", res_valid_o, 0);
    end
    drive(1'b0, 8'h00);
    chk("R2 first after refill", res_o, ref_f(8'hF0));
    chk("R8 valid after refill", res_valid_o, 1);
  endtask

  initial begin
    t_reset();
    t_comb();
    t_pipe();
    t_down();
    t_bubble_switch();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule